// File: doc/BRIEF.md
# DMA request edge-activation controller

This block is the request front end of one external DMA channel. It watches an active-low request pin and converts each new request into a single-cycle activation pulse for the transfer engine. A three-state loop paces the pin sensing against the engine. First a low level on the pin is awaited. Then the block waits until the engine reports that a transfer may start, and at that point the activation is issued. Then a high level on the pin is awaited before the next request is accepted. The result is that each falling edge of the pin produces one activation. The first activation after the channel is enabled comes from a low level on the pin and needs no observed high-to-low transition.

The block also holds the channel control register: enable, interrupt enable, interrupt flag, three pin-enable bits and a two-bit mode field. Software may not reconfigure the channel while it is enabled. A separate stop register gates the module clock. A request to stop is refused while the channel is enabled or an interrupt is pending. While stopped, the control register ignores writes and reads as zero, and the pin enables keep their settings.

Top module: `dma_req_edge_ctrl`

## Requirements
- R1: After reset, act_pulse, irq_out, clk_stop and pin_en are 0, and both registers read 0. Address 0 is the control register. Address 1 is the stop register, with the stop bit at bit 0.
- R2: Control register layout: bit 0 enable, bit 1 interrupt enable, bit 2 interrupt flag, bits 5:3 pin enables (driven on pin_en), bits 7:6 mode. Setting enable with the pin already low produces an activation once xfer_ready is high, without any high-to-low transition of the pin.
- R3: No activation is issued while xfer_ready is low. Each activation is a pulse exactly one cycle wide.
- R4: After an activation, a pin held low gives no further activation. After the pin returns high and then goes low again, exactly one more activation follows.
- R5: A write that clears enable is accepted while the channel is enabled. Once disabled, the block issues no activations, whatever the pin does.
- R6: While enabled, a control write changes only two things: it can clear enable, and it can clear the flag. Interrupt enable, pin enables and mode keep their values.
- R7: Writing 1 to the stop bit is refused while enable is set or irq_out is high. Otherwise it is accepted and drives clk_stop high. Writing 0 to the stop bit always clears it.
- R8: While stopped, control writes have no effect and the control register reads 0. pin_en keeps its value.
- R9: A one-cycle xfer_done sets the flag when interrupt enable is 1. irq_out equals flag AND interrupt enable. Writing 0 to bit 2 clears the flag. When interrupt enable is 0, xfer_done leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_pin | input | 1 | Active-low request pin (asynchronous) |
| xfer_ready | input | 1 | Transfer engine can start a transfer |
| xfer_done | input | 1 | One-cycle transfer completion strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 1 | Register read address |
| rd_data | output | 8 | Register read data |
| act_pulse | output | 1 | One-cycle activation to the transfer engine |
| irq_out | output | 1 | Interrupt request |
| pin_en | output | 3 | Pin-enable settings |
| clk_stop | output | 1 | Module stop, gates the block clock |

## Verification
The hardest case to reach is the request-disabled state with the pin still held low. Reaching it takes an enable, a low pin and a ready engine, in that order. The bench enables the channel while the pin is already low and xfer_ready is low. It then raises xfer_ready and keeps the pin low for many cycles, counting activations on every falling clock edge. Only after that does it toggle the pin high and low again to show that re-arming depends on the high level. Refusal of the stop write is reached the same way: first the channel is enabled and a completion strobe sets the flag, then the stop is requested.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_REQ  = 2'd1,
    ST_WAIT_XFER = 2'd2,
    ST_REQ_OFF   = 2'd3
  } act_state_e;

  localparam int BIT_EN     = 0;
  localparam int BIT_IRQ_EN = 1;
  localparam int BIT_FLAG   = 2;
  localparam int PIN_LSB    = 3;
  localparam int PIN_W      = 3;
  localparam int MODE_LSB   = PIN_LSB + PIN_W;
  localparam int MODE_W     = 2;
  localparam int CTRL_W     = MODE_LSB + MODE_W;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic req_n_s,
  input  logic xfer_ready,
  output logic act_pulse
);

  act_state_e state_q, state_d;
  logic       act_q, act_d;

  always_comb begin
    state_d = state_q;
    act_d   = 1'b0;
    if (!chan_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:      state_d = ST_WAIT_REQ;
        ST_WAIT_REQ:  if (!req_n_s) state_d = ST_WAIT_XFER;
        ST_WAIT_XFER: if (xfer_ready) begin
                        state_d = ST_REQ_OFF;
                        act_d   = 1'b1;
                      end
        ST_REQ_OFF:   if (req_n_s) state_d = ST_WAIT_REQ;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
    end
  end

  assign act_pulse = act_q;

  // R3
  act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> !act_pulse);

  // R3
  act_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> (state_q == ST_REQ_OFF));

  // R2
  enable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |=> (state_q == ST_WAIT_REQ));

  // R4
  rearm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ_OFF && !req_n_s) |=> (state_q == ST_REQ_OFF || state_q == ST_IDLE));

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !$past(chan_en)) |-> !act_pulse);

endmodule

// File: rtl/dma_req_regs.sv
module dma_req_regs
  import dma_req_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              xfer_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              chan_en,
  output logic              irq_out,
  output logic [PIN_W-1:0]  pin_en,
  output logic              clk_stop
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] STOP_ADDR = ADDR_W'(1);

  logic              en_q, en_d;
  logic              irqen_q, irqen_d;
  logic              flag_q, flag_d;
  logic              stop_q, stop_d;
  logic [PIN_W-1:0]  pin_q, pin_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              ctrl_wr, stop_wr, irq_pend;

  assign irq_pend = flag_q & irqen_q;
  assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR) && !stop_q;
  assign stop_wr  = wr_en && (wr_addr == STOP_ADDR);

  always_comb begin
    en_d    = en_q;
    irqen_d = irqen_q;
    flag_d  = flag_q;
    pin_d   = pin_q;
    mode_d  = mode_q;
    if (ctrl_wr) begin
      if (en_q) begin
        en_d = wr_data[BIT_EN];
      end else begin
        en_d    = wr_data[BIT_EN];
        irqen_d = wr_data[BIT_IRQ_EN];
        pin_d   = wr_data[PIN_LSB +: PIN_W];
        mode_d  = wr_data[MODE_LSB +: MODE_W];
      end
      if (!wr_data[BIT_FLAG]) flag_d = 1'b0;
    end
    if (xfer_done && irqen_q && !stop_q) flag_d = 1'b1;
  end

  always_comb begin
    stop_d = stop_q;
    if (stop_wr) begin
      if (!wr_data[0])               stop_d = 1'b0;
      else if (!en_q && !irq_pend)   stop_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      irqen_q <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= '0;
      mode_q  <= '0;
      stop_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      irqen_q <= irqen_d;
      flag_q  <= flag_d;
      pin_q   <= pin_d;
      mode_q  <= mode_d;
      stop_q  <= stop_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_ADDR && !stop_q) begin
      rd_data[BIT_EN]                = en_q;
      rd_data[BIT_IRQ_EN]            = irqen_q;
      rd_data[BIT_FLAG]              = flag_q;
      rd_data[PIN_LSB +: PIN_W]      = pin_q;
      rd_data[MODE_LSB +: MODE_W]    = mode_q;
    end else if (rd_addr == STOP_ADDR) begin
      rd_data[0] = stop_q;
    end
  end

  assign chan_en  = en_q;
  assign irq_out  = irq_pend;
  assign pin_en   = pin_q;
  assign clk_stop = stop_q;

  // R7
  stop_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(!en_q && !irq_pend));

  // R6
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> ($stable(mode_q) && $stable(pin_q) && $stable(irqen_q)));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_q) |-> ($stable(pin_q) && $stable(en_q)));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && irqen_q && !stop_q) |=> flag_q);

endmodule

// File: rtl/dma_req_edge_ctrl.sv
module dma_req_edge_ctrl
  import dma_req_pkg::*;
#(
  parameter int ADDR_W      = 1,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n_pin,
  input  logic              xfer_ready,
  input  logic              xfer_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              act_pulse,
  output logic              irq_out,
  output logic [PIN_W-1:0]  pin_en,
  output logic              clk_stop
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       req_n_s;
  logic       chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dma_req_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .din  (req_n_pin),
    .dout (req_n_s)
  );

  dma_req_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .xfer_done(xfer_done),
    .rd_data  (rd_data),
    .chan_en  (chan_en),
    .irq_out  (irq_out),
    .pin_en   (pin_en),
    .clk_stop (clk_stop)
  );

  dma_req_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .chan_en   (chan_en),
    .req_n_s   (req_n_s),
    .xfer_ready(xfer_ready),
    .act_pulse (act_pulse)
  );

endmodule

// File: tb/dma_req_edge_ctrl_bench.sv
module dma_req_edge_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_n_pin = 1'b1;
  logic       xfer_ready = 1'b0;
  logic       xfer_done = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [0:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       act_pulse;
  logic       irq_out;
  logic [2:0] pin_en;
  logic       clk_stop;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  logic prev_act = 1'b0;
  logic wide_seen = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_edge_ctrl u_dma_req_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n_pin(req_n_pin), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .act_pulse(act_pulse), .irq_out(irq_out),
    .pin_en(pin_en), .clk_stop(clk_stop)
  );

  always @(negedge clk) begin
    if (act_pulse) pulse_cnt <= pulse_cnt + 1;
    if (act_pulse && prev_act) wide_seen <= 1'b1;
    prev_act <= act_pulse;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic done_strobe();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    wait_cyc(6);
    chk("R1 act_pulse", act_pulse, 0);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 clk_stop", clk_stop, 0);
    chk("R1 pin_en", pin_en, 0);
    rd_chk("R1 ctrl read", 1'b0, 8'h00);
    rd_chk("R1 stop read", 1'b1, 8'h00);
  endtask

  task automatic t_activation();
    int base;
    req_n_pin = 1'b0;
    wait_cyc(4);
    base = pulse_cnt;
    wr(1'b0, 8'h01);
    wait_cyc(10);
    chk("R3 no pulse without ready", pulse_cnt - base, 0);
    xfer_ready = 1'b1;
    wait_cyc(10);
    chk("R2 first activation from low level", pulse_cnt - base, 1);
    wait_cyc(20);
    chk("R4 held low no repeat", pulse_cnt - base, 1);
    req_n_pin = 1'b1;
    wait_cyc(8);
    chk("R4 high alone no pulse", pulse_cnt - base, 1);
    req_n_pin = 1'b0;
    wait_cyc(10);
    chk("R4 new falling edge", pulse_cnt - base, 2);
    chk("R3 pulse width one cycle", wide_seen, 0);
  endtask

  task automatic t_disable();
    int base;
    req_n_pin = 1'b1;
    wait_cyc(6);
    wr(1'b0, 8'h00);
    rd_chk("R5 enable cleared", 1'b0, 8'h00);
    base = pulse_cnt;
    for (int i = 0; i < 3; i++) begin
      req_n_pin = 1'b0; wait_cyc(6);
      req_n_pin = 1'b1; wait_cyc(6);
    end
    chk("R5 no pulse while disabled", pulse_cnt - base, 0);
  endtask

  task automatic t_cfg_lock();
    wr(1'b0, 8'hAA);
    rd_chk("R6 disabled write", 1'b0, 8'hAA);
    chk("R2 pin_en field", pin_en, 3'b101);
    wr(1'b0, 8'hAB);
    rd_chk("R6 enabled", 1'b0, 8'hAB);
    wr(1'b0, 8'h51);
    rd_chk("R6 write ignored while enabled", 1'b0, 8'hAB);
    chk("R6 pin_en unchanged", pin_en, 3'b101);
    wr(1'b1, 8'h01);
    rd_chk("R7 stop refused while enabled", 1'b1, 8'h00);
    chk("R7 clk_stop low", clk_stop, 0);
    wr(1'b0, 8'h00);
    rd_chk("R6 only enable cleared", 1'b0, 8'hAA);
  endtask

  task automatic t_irq();
    wr(1'b0, 8'hAB);
    done_strobe();
    rd_chk("R9 flag set", 1'b0, 8'hAF);
    chk("R9 irq_out high", irq_out, 1);
    wr(1'b0, 8'h04);
    rd_chk("R9 flag kept on write 1", 1'b0, 8'hAE);
    wr(1'b1, 8'h01);
    rd_chk("R7 stop refused irq pending", 1'b1, 8'h00);
    wr(1'b0, 8'hAA);
    rd_chk("R9 flag cleared", 1'b0, 8'hAA);
    chk("R9 irq_out low", irq_out, 0);
    wr(1'b0, 8'hA8);
    done_strobe();
    rd_chk("R9 no flag when irq disabled", 1'b0, 8'hA8);
  endtask

  task automatic t_stop();
    wr(1'b1, 8'h01);
    chk("R7 clk_stop set", clk_stop, 1);
    rd_chk("R7 stop read", 1'b1, 8'h01);
    rd_chk("R8 ctrl reads zero", 1'b0, 8'h00);
    wr(1'b0, 8'h03);
    chk("R8 pin_en kept", pin_en, 3'b101);
    wr(1'b1, 8'h00);
    chk("R7 stop cleared", clk_stop, 0);
    rd_chk("R8 write ignored in stop", 1'b0, 8'hA8);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_activation();
    t_disable();
    t_cfg_lock();
    t_irq();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule